// File: doc/BRIEF.md
# Hardware Reset Pin Sequencer

This block turns an active-low, asynchronous reset pin into the internal reset sequence of a storage device. The pin is first passed through a synchroniser. A low level then has to last a minimum number of clock cycles before it counts as a reset. A qualified reset produces a single abort pulse for the operation in progress. If a program operation was running at that moment, the block also flags the target data as indeterminate.

A fixed interval measured from the pin's falling edge models the internal reset time. When that interval ends, the block asks the command controller to return to read mode. The data outputs are tri-stated for as long as the synchronised pin stays low. If the internal reset completes while the pin is still low, the block reports standby, and accesses must be refused. After the pin is released, and only once the internal reset has completed, a wake-up interval runs before outputs are declared valid.

All intervals are given in nanoseconds and converted to cycle counts by rounding up, using the clock period parameter. With the defaults (8 ns clock, 500 ns minimum width, 20 us internal reset, 500 ns wake-up) the counts are 63, 2500 and 63 cycles.

Top module: `pinreset_sequencer`

## Requirements
- R1: The pin passes through a two-flop synchroniser: `data_hiz` rises exactly two clock edges after `reset_pin_n` is sampled low.
- R2: A low level that lasts fewer than MIN_CYC (default 63) synchronised cycles produces no `op_abort`, no `indet_flag`, no `read_mode_req` and no `standby`.
- R3: A low level of MIN_CYC or more synchronised cycles produces exactly one single-cycle `op_abort` pulse, issued on the MIN_CYC-th consecutive low sample.
- R4: `indet_flag` pulses in the same cycle as `op_abort` if and only if `prog_active` is high on the qualifying sample. It is never high without `op_abort`.
- R5: `read_mode_req` pulses exactly once per qualified reset, INT_CYC - MIN_CYC cycles (default 2437) after `op_abort`. This holds even if the pin rises before then.
- R6: `data_hiz` is high in exactly the cycles in which the synchronised pin is low.
- R7: If the pin is still low when `read_mode_req` fires, `standby` is high from that cycle until the synchronised pin rises. If the pin has already risen, `standby` never asserts.
- R8: `out_valid` is low from the first synchronised low sample until the wake-up is complete. When the pin is released after the internal reset, `out_valid` returns WAKE_CYC + 3 cycles after the pin is driven high. When the pin was released earlier, it returns WAKE_CYC cycles after `read_mode_req`.
- R9: While and after synchronous `rst`, with the pin high, `out_valid` is 1 and `op_abort`, `indet_flag`, `read_mode_req`, `data_hiz` and `standby` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset of the sequencer |
| reset_pin_n | input | 1 | Asynchronous active-low reset pin |
| prog_active | input | 1 | High while a program operation is running |
| op_abort | output | 1 | One-cycle pulse: terminate the running operation |
| indet_flag | output | 1 | One-cycle pulse with op_abort when a program was cut off |
| read_mode_req | output | 1 | One-cycle pulse: command controller returns to read mode |
| data_hiz | output | 1 | Tri-state enable for the data outputs |
| standby | output | 1 | Internal reset done while the pin is still low; refuse accesses |
| out_valid | output | 1 | Outputs are valid for read access |

## Verification
The bench probes the qualification boundary with pulses of MIN_CYC - 1 and MIN_CYC cycles. An off-by-one counter would abort on the short pulse or miss the exact one. A pulse released well before the internal reset ends checks that the sequence still runs to completion: a design that restarts wake-up at pin release would raise `out_valid` too early and skip `read_mode_req`. Long pulses check that standby appears and that the wake-up timing after release is exact. Pulses with and without `prog_active` catch an indeterminate flag that is stuck or tied to the wrong cycle. The count of tri-state cycles has to equal the pulse width, which exposes a tri-state enable that drops during standby.

// File: rtl/pinreset_pkg.sv
package pinreset_pkg;

    // Sequencer phases
    typedef enum logic [2:0] {
        PH_RUN    = 3'd0,   // normal operation, pin high
        PH_QUAL   = 3'd1,   // pin low, width not yet qualified
        PH_INTRST = 3'd2,   // qualified, internal reset interval running
        PH_STBY   = 3'd3,   // internal reset done, pin still low
        PH_WAKE   = 3'd4    // pin released, wake-up interval running
    } phase_e;

    // Registered single-cycle events from the sequencer
    typedef struct packed {
        logic abort;
        logic indet;
        logic done;
    } evt_t;

    // Round a duration in ns up to whole clock cycles
    function automatic int ns_to_cyc(input int dur_ns, input int clk_ns);
        return (dur_ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pinreset_sync.sv
module pinreset_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_async,
    output logic pin_sync
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= pin_async;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], pin_async};
            end
        end
    endgenerate

    assign pin_sync = chain[STAGES-1];
endmodule

// File: rtl/pinreset_fsm.sv
module pinreset_fsm
    import pinreset_pkg::*;
#(
    parameter int MIN_CYC  = 63,    // must be at least 2
    parameter int INT_CYC  = 2500,  // must exceed MIN_CYC
    parameter int WAKE_CYC = 63,
    parameter int CW       = 12
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   pin_hi,
    input  logic   prog_active,
    output phase_e phase,
    output evt_t   evt
);
    localparam logic [CW-1:0] QUAL_LAST = CW'(MIN_CYC - 1);
    localparam logic [CW-1:0] INT_LAST  = CW'(INT_CYC - 1);
    localparam logic [CW-1:0] WAKE_LAST = CW'(WAKE_CYC - 1);
    localparam logic [CW-1:0] ONE       = CW'(1);

    // One counter serves every phase: low samples since the fall while
    // qualifying and in internal reset, wake-up cycles after release.
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_RUN;
            cnt   <= '0;
            evt   <= '0;
        end else begin
            evt <= '0;
            unique case (phase)
                PH_RUN: begin
                    if (!pin_hi) begin
                        phase <= PH_QUAL;
                        cnt   <= ONE;
                    end
                end
                PH_QUAL: begin
                    if (pin_hi) begin
                        phase <= PH_RUN;          // too short: ignored
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + ONE;
                        if (cnt == QUAL_LAST) begin
                            phase     <= PH_INTRST;
                            evt.abort <= 1'b1;
                            evt.indet <= prog_active;
                        end
                    end
                end
                PH_INTRST: begin
                    // runs to completion whatever the pin does
                    if (cnt == INT_LAST) begin
                        evt.done <= 1'b1;
                        cnt      <= '0;
                        phase    <= pin_hi ? PH_WAKE : PH_STBY;
                    end else begin
                        cnt <= cnt + ONE;
                    end
                end
                PH_STBY: begin
                    if (pin_hi) begin
                        phase <= PH_WAKE;
                        cnt   <= '0;
                    end
                end
                PH_WAKE: begin
                    if (!pin_hi) begin
                        phase <= PH_QUAL;         // new fall restarts qualification
                        cnt   <= ONE;
                    end else if (cnt == WAKE_LAST) begin
                        phase <= PH_RUN;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + ONE;
                    end
                end
                default: begin
                    phase <= PH_RUN;
                    cnt   <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/pinreset_outs.sv
module pinreset_outs
    import pinreset_pkg::*;
(
    input  phase_e phase,
    input  evt_t   evt,
    input  logic   pin_hi,
    output logic   op_abort,
    output logic   indet_flag,
    output logic   read_mode_req,
    output logic   data_hiz,
    output logic   standby,
    output logic   out_valid
);
    always_comb begin
        op_abort      = evt.abort;
        indet_flag    = evt.abort & evt.indet;
        read_mode_req = evt.done;
        data_hiz      = ~pin_hi;
        standby       = (phase == PH_STBY) & ~pin_hi;
        out_valid     = (phase == PH_RUN) & pin_hi;
    end
endmodule

// File: rtl/pinreset_sequencer.sv
module pinreset_sequencer
    import pinreset_pkg::*;
#(
    parameter int CLK_NS      = 8,
    parameter int MIN_LOW_NS  = 500,
    parameter int INT_RST_NS  = 20000,
    parameter int WAKE_NS     = 500,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic reset_pin_n,
    input  logic prog_active,
    output logic op_abort,
    output logic indet_flag,
    output logic read_mode_req,
    output logic data_hiz,
    output logic standby,
    output logic out_valid
);
    localparam int MIN_CYC  = ns_to_cyc(MIN_LOW_NS, CLK_NS);
    localparam int INT_CYC  = ns_to_cyc(INT_RST_NS, CLK_NS);
    localparam int WAKE_CYC = ns_to_cyc(WAKE_NS, CLK_NS);
    localparam int CW       = $clog2(max3(MIN_CYC, INT_CYC, WAKE_CYC) + 1);

    logic   pin_hi;
    phase_e phase;
    evt_t   evt;

    pinreset_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .pin_async (reset_pin_n),
        .pin_sync  (pin_hi)
    );

    pinreset_fsm #(
        .MIN_CYC  (MIN_CYC),
        .INT_CYC  (INT_CYC),
        .WAKE_CYC (WAKE_CYC),
        .CW       (CW)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .pin_hi      (pin_hi),
        .prog_active (prog_active),
        .phase       (phase),
        .evt         (evt)
    );

    pinreset_outs u_outs (
        .phase         (phase),
        .evt           (evt),
        .pin_hi        (pin_hi),
        .op_abort      (op_abort),
        .indet_flag    (indet_flag),
        .read_mode_req (read_mode_req),
        .data_hiz      (data_hiz),
        .standby       (standby),
        .out_valid     (out_valid)
    );
endmodule

// File: rtl/pinreset_chk.sv
module pinreset_chk #(
    parameter int MIN_CYC = 63,
    parameter int INT_CYC = 2500
) (
    input logic clk,
    input logic rst,
    input logic reset_pin_n,
    input logic prog_active,
    input logic op_abort,
    input logic indet_flag,
    input logic read_mode_req,
    input logic data_hiz,
    input logic standby,
    input logic out_valid
);
    int low_run;    // consecutive tri-state cycles, saturating
    int gap;        // cycles since the last abort, 0 when not armed

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run <= 0;
            gap     <= 0;
        end else begin
            if (!data_hiz)              low_run <= 0;
            else if (low_run <= MIN_CYC) low_run <= low_run + 1;
            if (op_abort)           gap <= 1;
            else if (read_mode_req) gap <= 0;
            else if (gap != 0)      gap <= gap + 1;
        end
    end

    // R2/R3: abort only on exactly the MIN_CYC-th low sample
    assert_abort_at_min_R3: assert property (@(posedge clk) disable iff (rst)
        op_abort |-> (low_run == MIN_CYC));

    assert_abort_single_R3: assert property (@(posedge clk) disable iff (rst)
        op_abort |=> !op_abort);

    assert_indet_with_abort_R4: assert property (@(posedge clk) disable iff (rst)
        indet_flag |-> op_abort);

    assert_req_gap_R5: assert property (@(posedge clk) disable iff (rst)
        read_mode_req |-> (gap == INT_CYC - MIN_CYC));

    assert_standby_hiz_R7: assert property (@(posedge clk) disable iff (rst)
        standby |-> data_hiz);

    assert_valid_not_hiz_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !data_hiz);

    assert_valid_not_abort_R8: assert property (@(posedge clk) disable iff (rst)
        (op_abort || read_mode_req) |-> !out_valid);
endmodule

bind pinreset_sequencer pinreset_chk #(
    .MIN_CYC (MIN_CYC),
    .INT_CYC (INT_CYC)
) u_chk (.*);

// File: tb/tb_pinreset_sequencer.sv
module tb_pinreset_sequencer;
    localparam int CLK_NS = 8;
    localparam int BMIN   = (500 + CLK_NS - 1) / CLK_NS;     // 63
    localparam int BINT   = (20000 + CLK_NS - 1) / CLK_NS;   // 2500
    localparam int BWAKE  = (500 + CLK_NS - 1) / CLK_NS;     // 63

    typedef struct packed {
        logic [31:0] low;     // low width in cycles
        logic        busy;    // prog_active during pulse
        logic        ab;      // expect abort
        logic        ind;     // expect indeterminate flag
        logic        sb;      // expect standby
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{32'd5,        1'b0, 1'b0, 1'b0, 1'b0},
        '{32'(BMIN-1),  1'b1, 1'b0, 1'b0, 1'b0},
        '{32'(BMIN),    1'b0, 1'b1, 1'b0, 1'b0},
        '{32'(BMIN),    1'b1, 1'b1, 1'b1, 1'b0},
        '{32'd3000,     1'b1, 1'b1, 1'b1, 1'b1},
        '{32'd300,      1'b0, 1'b1, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reset_pin_n = 1'b1;
    logic prog_active = 1'b0;
    logic op_abort, indet_flag, read_mode_req, data_hiz, standby, out_valid;

    pinreset_sequencer dut (
        .clk (clk), .rst (rst), .reset_pin_n (reset_pin_n),
        .prog_active (prog_active), .op_abort (op_abort),
        .indet_flag (indet_flag), .read_mode_req (read_mode_req),
        .data_hiz (data_hiz), .standby (standby), .out_valid (out_valid)
    );

    always #4 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    int cyc = 0;
    int n_abort, n_indet, n_req, n_hiz;
    int abort_cyc, req_cyc, valid_cyc, rel_cyc;
    bit sb_seen;
    bit prev_valid = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (op_abort)      begin n_abort++; abort_cyc = cyc; end
        if (indet_flag)    n_indet++;
        if (read_mode_req) begin n_req++; req_cyc = cyc; end
        if (data_hiz)      n_hiz++;
        if (standby)       sb_seen = 1'b1;
        if (out_valid && !prev_valid) valid_cyc = cyc;
        prev_valid = out_valid;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(negedge clk); #1;
        n_abort = 0; n_indet = 0; n_req = 0; n_hiz = 0;
        sb_seen = 1'b0; abort_cyc = 0; req_cyc = 0; valid_cyc = 0;
    endtask

    task automatic wait_valid();
        for (int i = 0; i < BINT + BWAKE + 100 && !out_valid; i++) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    task automatic run_vec(input vec_t v);
        int w;
        w = int'(v.low);
        clear_mon();
        prog_active = v.busy;
        reset_pin_n = 1'b0;
        repeat (w) @(posedge clk);
        @(negedge clk); #1;
        reset_pin_n = 1'b1;
        rel_cyc = cyc;
        wait_valid();
        prog_active = 1'b0;
        check(n_hiz == w, "R6 tri-state cycles", n_hiz, w);
        check(n_abort == int'(v.ab), v.ab ? "R3 abort count" : "R2 short pulse abort", n_abort, int'(v.ab));
        check(n_indet == int'(v.ind), "R4 indeterminate count", n_indet, int'(v.ind));
        check(n_req == int'(v.ab), v.ab ? "R5 read-mode count" : "R2 short pulse read-mode", n_req, int'(v.ab));
        check(sb_seen == v.sb, "R7 standby seen", int'(sb_seen), int'(v.sb));
        check(out_valid == 1'b1, "R8 valid restored", int'(out_valid), 1);
        if (v.ab) begin
            check(req_cyc - abort_cyc == BINT - BMIN, "R5 abort to read-mode gap",
                  req_cyc - abort_cyc, BINT - BMIN);
            if (v.sb)
                check(valid_cyc - rel_cyc == BWAKE + 3, "R8 wake after release",
                      valid_cyc - rel_cyc, BWAKE + 3);
            else
                check(valid_cyc - req_cyc == BWAKE, "R8 wake after early release",
                      valid_cyc - req_cyc, BWAKE);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b1 && data_hiz == 1'b0, "R9 valid in reset", int'(out_valid), 1);
        #1 rst = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b1, "R9 out_valid after reset", int'(out_valid), 1);
        check(data_hiz == 1'b0 && standby == 1'b0, "R9 hiz/standby after reset",
              int'(data_hiz) + int'(standby), 0);
        check(op_abort == 1'b0 && indet_flag == 1'b0 && read_mode_req == 1'b0,
              "R9 pulses idle after reset", int'(op_abort) + int'(indet_flag) + int'(read_mode_req), 0);

        // Vector table
        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R1: synchroniser latency
        clear_mon();
        reset_pin_n = 1'b0;
        @(negedge clk);
        check(data_hiz == 1'b0, "R1 hiz after one edge", int'(data_hiz), 0);
        @(negedge clk);
        check(data_hiz == 1'b1, "R1 hiz after two edges", int'(data_hiz), 1);
        check(out_valid == 1'b0, "R8 valid drops on low", int'(out_valid), 0);
        #1 reset_pin_n = 1'b1;
        wait_valid();
        check(n_abort == 0, "R2 two-cycle glitch ignored", n_abort, 0);

        // R7: standby persists while pin low, clears on release
        clear_mon();
        reset_pin_n = 1'b0;
        repeat (BINT + 20) @(negedge clk);
        check(standby == 1'b1, "R7 standby while low", int'(standby), 1);
        #1 reset_pin_n = 1'b1;
        repeat (3) @(negedge clk);
        check(standby == 1'b0, "R7 standby clears on release", int'(standby), 0);
        check(out_valid == 1'b0, "R8 not valid during wake", int'(out_valid), 0);
        wait_valid();
        check(out_valid == 1'b1, "R8 valid after wake", int'(out_valid), 1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule